// File: doc/BRIEF.md
# Programmable Dot-Clock Display Timing Generator

This block drives a parallel RGB panel. It advances one step per pixel clock and produces horizontal sync, vertical sync, data enable and a pixel request toward a line FIFO. Software programs the frame geometry through a small word-addressed register port. The geometry covers the total line and frame lengths, the two sync pulse widths, and two wait counts measured from the start of each sync pulse to the first active pixel or line. It also covers how many pixels per line are shown, how many of those are fetched from the FIFO, and how many lines are active.

The block holds two frame-buffer bases, a pending one and a live one. The pending base is adopted only at the top of a frame. On every active line the block publishes a line-start pulse with that line's memory address, which is the live base plus a programmable stride per line. Pixel data is taken from the FIFO with a ready/valid handshake and presented on the pixel output in the same cycle.

Stopping is graceful. When the run request is withdrawn, timing keeps going until the FIFO reports no more data, and only then does the running status drop. While the block is idle, its counters are held at zero, so every start begins with a complete vertical sync.

Top module: `dotclk_timing_gen`

## Requirements
- R1: A line lasts `h_period` clocks (HTIM bits 17:0). The horizontal sync is active for the first `hs_width` clocks of the line (HTIM bits 31:18).
- R2: A frame lasts `v_lines` lines (VTIM bits 15:0). The vertical sync is active during the first `vs_width` lines (VTIM bits 31:16). The pulse starts at horizontal position 0 of line 0.
- R3: Data enable is active when both of these hold: the horizontal position is at or above `h_wait` (WAIT bits 27:16) and below `h_wait + h_valid` (HVALID bits 17:0); the line is at or above `v_wait` (WAIT bits 15:0) and below `v_wait + act_lines` (XFER bits 31:16).
- R4: The FIFO ready output is active on the first `act_pix` (XFER bits 15:0) enabled pixels of each line. The pixel output equals the FIFO data when both ready and valid are high, and zero otherwise.
- R5: CTRL bits 2, 3 and 4 make hsync, vsync and data enable active-high when set and active-low when clear. CTRL bit 5 appears directly on the pixel-edge select output.
- R6: While CTRL bit 1 (sync enable) is clear, both sync outputs stay at their inactive level. Data enable keeps running.
- R7: A base written to NEXT (offset 0x60) is copied into CUR (offset 0x70, read-only) only at the first pixel of a frame. Until then, CUR keeps its old value.
- R8: Frame start pulses at position (0,0). Line start pulses at `h_wait` on each active line, and the line address is then CUR plus (line − `v_wait`) times STRIDE (offset 0x80).
- R9: Each register at base offset B (a multiple of 0x10) is written at B, set bitwise at B+4 and cleared bitwise at B+8. Only the bits written as 1 change through the set and clear aliases.
- R10: CTRL bit 0 requests running. Read bit 16 of CTRL shows running status. After the request is cleared, status stays high while FIFO valid is high. Status falls once valid is low, and timing then restarts from zero.
- R11: After reset, all registers read zero. The sync and data-enable outputs are at the inactive level for active-low polarity (high), and no pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fifo_valid | input | 1 | FIFO has pixel data |
| fifo_data | input | 24 | FIFO pixel data |
| fifo_ready | output | 1 | Pixel request to FIFO |
| pix_data | output | 24 | Pixel data to panel |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_fall_o | output | 1 | Pixel clock edge select |
| frame_start_o | output | 1 | One-clock pulse at first position of frame |
| line_start_o | output | 1 | One-clock pulse at start of each active line |
| line_addr_o | output | 32 | Memory address of the line just started |

## Verification
The bench programs a tiny panel: 12 clocks per line, 8 lines per frame, a 2-clock hsync, a 1-line vsync, a 5-pixel visible window of which 4 are fetched, and 3 active lines. A full 96-clock frame then fits in a short sweep. Every position of that frame is compared against arithmetic expectations, and the sweep is repeated across both polarity sets, with syncs gated, and across a base-address change. These small values also make the drain-then-restart path and the alias writes reachable within a few hundred cycles.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DW      = 32;
  localparam int H_W     = 18;
  localparam int V_W     = 16;
  localparam int HWAIT_W = 12;
  localparam int HSW_W   = 14;
  localparam int NREG    = 9;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_VTIM   = 1;
  localparam int IDX_HTIM   = 2;
  localparam int IDX_WAIT   = 3;
  localparam int IDX_XFER   = 4;
  localparam int IDX_HVAL   = 5;
  localparam int IDX_NEXT   = 6;
  localparam int IDX_CUR    = 7;
  localparam int IDX_STRIDE = 8;

  localparam int B_RUN  = 0;
  localparam int B_SYNC = 1;
  localparam int B_HSHI = 2;
  localparam int B_VSHI = 3;
  localparam int B_DEHI = 4;
  localparam int B_CLKF = 5;
  localparam int B_STAT = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} run_st_t;

  typedef struct packed {
    logic               run_req;
    logic               sync_en;
    logic               hs_hi;
    logic               vs_hi;
    logic               de_hi;
    logic               clk_fall;
    logic [H_W-1:0]     h_period;
    logic [HSW_W-1:0]   hs_width;
    logic [HWAIT_W-1:0] h_wait;
    logic [H_W-1:0]     h_valid;
    logic [V_W-1:0]     act_pix;
    logic [V_W-1:0]     v_lines;
    logic [V_W-1:0]     vs_width;
    logic [V_W-1:0]     v_wait;
    logic [V_W-1:0]     act_lines;
  } dtg_cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              running,
  input  logic [DW-1:0]     cur_buf,
  output dtg_cfg_t          cfg,
  output logic [DW-1:0]     next_buf,
  output logic [DW-1:0]     stride
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]          idx;
  logic [1:0]                op;
  logic                      aligned;
  logic [NREG-1:0][DW-1:0]   rf;

  assign idx     = addr[ADDR_W-1:4];
  assign op      = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_CUR) begin : g_ro
      assign rf[i] = '0;
    end else begin : g_rw
      logic          hit;
      logic [DW-1:0] d;
      logic [DW-1:0] q;
      assign hit = we && aligned && (idx == IDX_W'(i)) && (op != 2'd3);
      always_comb begin
        case (op)
          2'd0:    d = wdata;
          2'd1:    d = q | wdata;
          default: d = q & ~wdata;
        endcase
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= d;
      end
      assign rf[i] = q;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(IDX_CTRL))      rdata = rf[IDX_CTRL] | (DW'(running) << B_STAT);
    else if (idx == IDX_W'(IDX_CUR))  rdata = cur_buf;
    else if (idx < IDX_W'(NREG))      rdata = rf[idx];
  end

  assign cfg.run_req   = rf[IDX_CTRL][B_RUN];
  assign cfg.sync_en   = rf[IDX_CTRL][B_SYNC];
  assign cfg.hs_hi     = rf[IDX_CTRL][B_HSHI];
  assign cfg.vs_hi     = rf[IDX_CTRL][B_VSHI];
  assign cfg.de_hi     = rf[IDX_CTRL][B_DEHI];
  assign cfg.clk_fall  = rf[IDX_CTRL][B_CLKF];
  assign cfg.v_lines   = rf[IDX_VTIM][V_W-1:0];
  assign cfg.vs_width  = rf[IDX_VTIM][DW-1:DW-V_W];
  assign cfg.h_period  = rf[IDX_HTIM][H_W-1:0];
  assign cfg.hs_width  = rf[IDX_HTIM][DW-1:DW-HSW_W];
  assign cfg.h_wait    = rf[IDX_WAIT][16+HWAIT_W-1:16];
  assign cfg.v_wait    = rf[IDX_WAIT][V_W-1:0];
  assign cfg.act_pix   = rf[IDX_XFER][V_W-1:0];
  assign cfg.act_lines = rf[IDX_XFER][DW-1:DW-V_W];
  assign cfg.h_valid   = rf[IDX_HVAL][H_W-1:0];
  assign next_buf      = rf[IDX_NEXT];
  assign stride        = rf[IDX_STRIDE];

  // p_alias_set_r9: a set-alias write never clears a bit of the target register
  p_alias_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && aligned && op == 2'd1 && idx == IDX_W'(IDX_STRIDE))
      |=> ((stride & $past(stride)) == $past(stride)));
endmodule

// File: rtl/dtg_seq.sv
module dtg_seq
  import dtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_req,
  input  logic           fifo_valid,
  input  logic [H_W-1:0] h_period,
  input  logic [V_W-1:0] v_lines,
  output logic [H_W-1:0] hcnt,
  output logic [V_W-1:0] vcnt,
  output logic           active
);
  run_st_t        st_q, st_d;
  logic [H_W-1:0] hcnt_d;
  logic [V_W-1:0] vcnt_d;
  logic           h_last, v_last;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (run_req) st_d = ST_RUN;
      ST_RUN:   if (!run_req) st_d = ST_DRAIN;
      ST_DRAIN: if (run_req) st_d = ST_RUN;
                else if (!fifo_valid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign active = (st_q != ST_IDLE);
  assign h_last = (hcnt == h_period - H_W'(1));
  assign v_last = (vcnt == v_lines - V_W'(1));

  always_comb begin
    hcnt_d = hcnt;
    vcnt_d = vcnt;
    if (!active) begin
      hcnt_d = '0;
      vcnt_d = '0;
    end else if (h_last) begin
      hcnt_d = '0;
      vcnt_d = v_last ? '0 : vcnt + V_W'(1);
    end else begin
      hcnt_d = hcnt + H_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      st_q <= st_d;
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end

  // p_hstep_r1: within a running line the horizontal position advances by one
  p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && hcnt != '0) |-> (hcnt == $past(hcnt) + H_W'(1)));
  // p_idle_zero_r11: an idle cycle leaves both counters at zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> (hcnt == '0 && vcnt == '0));
  // p_drain_hold_r10: draining with data still present does not stop
  p_drain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && fifo_valid) |=> (st_q != ST_IDLE));
endmodule

// File: rtl/dtg_out.sv
module dtg_out
  import dtg_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dtg_cfg_t         cfg,
  input  logic [H_W-1:0]   hcnt,
  input  logic [V_W-1:0]   vcnt,
  input  logic             active,
  input  logic [DW-1:0]    next_buf,
  input  logic [DW-1:0]    stride,
  input  logic             fifo_valid,
  input  logic [PIX_W-1:0] fifo_data,
  output logic             fifo_ready,
  output logic [PIX_W-1:0] pix_data,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             frame_start_o,
  output logic             line_start_o,
  output logic [DW-1:0]    line_addr_o,
  output logic [DW-1:0]    cur_buf
);
  logic [H_W-1:0] hw;
  logic [H_W:0]   h_end;
  logic [V_W:0]   v_end;
  logic [H_W-1:0] h_off;
  logic           h_in, v_in;
  logic           hs_d, vs_d, de_d, rdy_d, fs_d, ls_d;
  logic           hs_q, vs_q, de_q, rdy_q, fs_q, ls_q;
  logic [DW-1:0]  ptr_q, ptr_d, base, addr_d;

  assign hw    = H_W'(cfg.h_wait);
  assign h_end = {1'b0, hw} + {1'b0, cfg.h_valid};
  assign v_end = {1'b0, cfg.v_wait} + {1'b0, cfg.act_lines};
  assign h_off = hcnt - hw;
  assign h_in  = (hcnt >= hw) && ({1'b0, hcnt} < h_end);
  assign v_in  = (vcnt >= cfg.v_wait) && ({1'b0, vcnt} < v_end);

  always_comb begin
    hs_d  = active && cfg.sync_en && (hcnt < H_W'(cfg.hs_width));
    vs_d  = active && cfg.sync_en && (vcnt < cfg.vs_width);
    de_d  = active && h_in && v_in;
    rdy_d = de_d && (h_off < H_W'(cfg.act_pix));
    fs_d  = active && (hcnt == '0) && (vcnt == '0);
    ls_d  = active && v_in && (hcnt == hw);
  end

  always_comb begin
    base   = fs_d ? next_buf : ptr_q;
    ptr_d  = ptr_q;
    addr_d = line_addr_o;
    if (ls_d) begin
      addr_d = base;
      ptr_d  = base + stride;
    end else if (fs_d) begin
      ptr_d  = next_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q        <= 1'b0;
      vs_q        <= 1'b0;
      de_q        <= 1'b0;
      rdy_q       <= 1'b0;
      fs_q        <= 1'b0;
      ls_q        <= 1'b0;
      ptr_q       <= '0;
      line_addr_o <= '0;
      cur_buf     <= '0;
    end else begin
      hs_q        <= hs_d;
      vs_q        <= vs_d;
      de_q        <= de_d;
      rdy_q       <= rdy_d;
      fs_q        <= fs_d;
      ls_q        <= ls_d;
      ptr_q       <= ptr_d;
      line_addr_o <= addr_d;
      if (fs_d) cur_buf <= next_buf;
    end
  end

  assign hsync_o       = cfg.hs_hi ? hs_q : ~hs_q;
  assign vsync_o       = cfg.vs_hi ? vs_q : ~vs_q;
  assign de_o          = cfg.de_hi ? de_q : ~de_q;
  assign fifo_ready    = rdy_q;
  assign pix_data      = (rdy_q && fifo_valid) ? fifo_data : '0;
  assign frame_start_o = fs_q;
  assign line_start_o  = ls_q;

  // p_ready_in_de_r4: a pixel is only requested inside the enabled window
  p_ready_in_de_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> de_q);
  // p_cur_swap_r7: the live base takes the pending base at frame start
  p_cur_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (cur_buf == $past(next_buf)));
  // p_sync_gate_r6: with sync disabled neither sync pulse is produced
  p_sync_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg.sync_en) |-> (!hs_q && !vs_q));
  // p_fs_vsync_r2: the vertical pulse is active at the first position of a frame
  p_fs_vsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && $past(cfg.sync_en) && $past(cfg.vs_width) != '0) |-> vs_q);
endmodule

// File: rtl/dotclk_timing_gen.sv
module dotclk_timing_gen
  import dtg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              fifo_valid,
  input  logic [PIX_W-1:0]  fifo_data,
  output logic              fifo_ready,
  output logic [PIX_W-1:0]  pix_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_fall_o,
  output logic              frame_start_o,
  output logic              line_start_o,
  output logic [DW-1:0]     line_addr_o
);
  dtg_cfg_t       cfg;
  logic [DW-1:0]  next_buf, stride, cur_buf;
  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt;
  logic           active;

  dtg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .running  (active),
    .cur_buf  (cur_buf),
    .cfg      (cfg),
    .next_buf (next_buf),
    .stride   (stride)
  );

  dtg_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (cfg.run_req),
    .fifo_valid (fifo_valid),
    .h_period   (cfg.h_period),
    .v_lines    (cfg.v_lines),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .active     (active)
  );

  dtg_out #(.PIX_W(PIX_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg           (cfg),
    .hcnt          (hcnt),
    .vcnt          (vcnt),
    .active        (active),
    .next_buf      (next_buf),
    .stride        (stride),
    .fifo_valid    (fifo_valid),
    .fifo_data     (fifo_data),
    .fifo_ready    (fifo_ready),
    .pix_data      (pix_data),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .de_o          (de_o),
    .frame_start_o (frame_start_o),
    .line_start_o  (line_start_o),
    .line_addr_o   (line_addr_o),
    .cur_buf       (cur_buf)
  );

  assign pclk_fall_o = cfg.clk_fall;
endmodule

// File: tb/sim_dotclk_timing_gen.sv
module sim_dotclk_timing_gen;
  localparam int HP = 12, HS = 2, HWT = 4, HV = 5, AP = 4;
  localparam int VL = 8, VS = 1, VWT = 2, AL = 3;
  localparam logic [31:0] STRIDE = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        fifo_valid;
  logic [23:0] fifo_data;
  logic        fifo_ready;
  logic [23:0] pix_data;
  logic        hsync_o, vsync_o, de_o, pclk_fall_o;
  logic        frame_start_o, line_start_o;
  logic [31:0] line_addr_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dotclk_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_ready(fifo_ready), .pix_data(pix_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_fall_o(pclk_fall_o),
    .frame_start_o(frame_start_o), .line_start_o(line_start_o),
    .line_addr_o(line_addr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_fs(output int waited);
    waited = 0;
    while (!frame_start_o && waited < 400) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // one full frame compared position by position (R1 R2 R3 R4 R8)
  task automatic sweep(input bit hs_hi, input bit vs_hi, input bit de_hi,
                       input bit sen, input logic [31:0] base);
    int w;
    wait_fs(w);
    chk("R8 frame start found", 32'(frame_start_o), 32'd1);
    for (int c = 0; c < HP * VL; c++) begin
      int h, v;
      bit hs_a, vs_a, hin, vin, de_a, rdy, fs, ls;
      h = c % HP;
      v = c / HP;
      fifo_valid = ((c % 5) != 3);
      fifo_data  = 24'(c * 3 + 1);
      #1;
      hs_a = sen && (h < HS);
      vs_a = sen && (v < VS);
      hin  = (h >= HWT) && (h < HWT + HV);
      vin  = (v >= VWT) && (v < VWT + AL);
      de_a = hin && vin;
      rdy  = de_a && (h - HWT < AP);
      fs   = (h == 0) && (v == 0);
      ls   = vin && (h == HWT);
      chk("R1 hsync", 32'(hsync_o), 32'(hs_hi ? hs_a : !hs_a));
      chk("R2 vsync", 32'(vsync_o), 32'(vs_hi ? vs_a : !vs_a));
      chk("R3 data enable", 32'(de_o), 32'(de_hi ? de_a : !de_a));
      chk("R4 fifo ready", 32'(fifo_ready), 32'(rdy));
      chk("R4 pixel data", 32'(pix_data), (rdy && fifo_valid) ? 32'(c * 3 + 1) : 32'd0);
      chk("R8 frame start", 32'(frame_start_o), 32'(fs));
      chk("R8 line start", 32'(line_start_o), 32'(ls));
      if (ls) chk("R8 line address", line_addr_o, base + 32'(v - VWT) * STRIDE);
      @(negedge clk);
    end
    fifo_valid = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    fifo_valid = 1'b0; fifo_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    reg_rd(8'h00, rd); chk("R11 ctrl reset", rd, 32'h0);
    reg_rd(8'h20, rd); chk("R11 htim reset", rd, 32'h0);
    reg_rd(8'h70, rd); chk("R11 cur reset", rd, 32'h0);
    chk("R11 hsync idle", 32'(hsync_o), 32'd1);
    chk("R11 vsync idle", 32'(vsync_o), 32'd1);
    chk("R11 de idle", 32'(de_o), 32'd1);
    chk("R11 no frame pulse", 32'(frame_start_o), 32'd0);
    chk("R11 no ready", 32'(fifo_ready), 32'd0);

    reg_wr(8'h10, (32'(VS) << 16) | 32'(VL));
    reg_wr(8'h20, (32'(HS) << 18) | 32'(HP));
    reg_wr(8'h30, (32'(HWT) << 16) | 32'(VWT));
    reg_wr(8'h40, (32'(AL) << 16) | 32'(AP));
    reg_wr(8'h50, 32'(HV));
    reg_wr(8'h60, 32'h1000);
    reg_wr(8'h80, STRIDE);
    reg_rd(8'h30, rd); chk("R9 plain write", rd, (32'(HWT) << 16) | 32'(VWT));

    // R9 aliases on CTRL
    reg_wr(8'h00, 32'h1E);
    reg_wr(8'h04, 32'h01);
    reg_rd(8'h00, rd); chk("R9 set alias keeps others", rd & 32'hFFFF, 32'h1F);
    fifo_valid = 1'b1;
    @(negedge clk);
    reg_rd(8'h00, rd); chk("R10 running status", (rd >> 16) & 32'h1, 32'h1);

    sweep(1, 1, 1, 1, 32'h1000);

    // R7 pending base adopted only at frame start
    reg_wr(8'h60, 32'h2000);
    reg_rd(8'h70, rd); chk("R7 cur holds before frame", rd, 32'h1000);
    sweep(1, 1, 1, 1, 32'h2000);
    reg_rd(8'h70, rd); chk("R7 cur after frame", rd, 32'h2000);

    // R5 polarity to active-low via clear alias, edge select via set alias
    reg_wr(8'h08, 32'h1C);
    reg_wr(8'h04, 32'h20);
    reg_rd(8'h00, rd); chk("R9 clear alias", rd, 32'h10023);
    chk("R5 pixel edge select", 32'(pclk_fall_o), 32'd1);
    sweep(0, 0, 0, 1, 32'h2000);

    // R6 sync gating
    reg_wr(8'h08, 32'h02);
    sweep(0, 0, 0, 0, 32'h2000);

    // R10 drain
    fifo_valid = 1'b1;
    reg_wr(8'h08, 32'h01);
    for (int i = 0; i < 40; i++) begin
      reg_rd(8'h00, rd);
      chk("R10 status held while draining", (rd >> 16) & 32'h1, 32'h1);
      @(negedge clk);
    end
    fifo_valid = 1'b0;
    repeat (3) @(negedge clk);
    reg_rd(8'h00, rd); chk("R10 status cleared", (rd >> 16) & 32'h1, 32'h0);
    chk("R10 de idle after drain", 32'(de_o), 32'd1);
    chk("R10 no ready after drain", 32'(fifo_ready), 32'd0);

    // R10 restart begins with a full vsync
    reg_wr(8'h04, 32'h03);
    wait_fs(w);
    chk("R10 prompt restart", 32'(w <= 3), 32'd1);
    chk("R10 vsync at restart", 32'(vsync_o), 32'd0);
    chk("R10 hsync at restart", 32'(hsync_o), 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule